// File: doc/BRIEF.md
# SEC-DED Memory Word Codec with Error Counters

This block protects a 64-bit memory word with 8 check bits using a single-error-correcting, double-error-detecting code. Every column of the parity-check matrix has an odd number of ones. The write side is purely combinational. It turns the data word about to be stored into its check bits, which the caller stores next to the data.

The read side takes a stored data word and its stored check bits and recomputes the syndrome. It returns the word one clock later, repaired when a single bit has flipped. It also raises one of two flags: the word was repaired, or the word cannot be trusted.

Two saturating counters, one per error kind, record how often each case happened, so that a failing memory can be spotted before it loses data. Software clears both counters through a synchronous clear input.

The decode path has the same register stage whether or not an error is present. A clean read therefore costs no more than a plain registered read.

Top module: `secded_codec`

## Requirements
- R1: The check bits are a linear function of the data. All-zero data gives all-zero check bits, and the check bits of `a ^ b` equal the XOR of the check bits of `a` and of `b`.
- R2: Each data bit drives an odd number of check bits. Data bits 0..55 each drive exactly three check bits and bits 56..63 each drive exactly five, so a data word with a single one always yields check bits of odd weight.
- R3: A read whose stored data and check bits agree returns that data unchanged, with both flags low.
- R4: A read with exactly one flipped bit, in the data or in the check bits, returns the data as originally written and raises the correctable flag only.
- R5: A read with exactly two flipped bits raises the uncorrectable flag only and returns the stored data unmodified.
- R6: An odd-weight syndrome that equals no matrix column is reported as uncorrectable. Stored check bits XORed with 8'h7F (weight seven, which no column has) give this case.
- R7: `dec_valid`, `dec_data`, `ce` and `ue` are registered and appear in the cycle after `rd_valid`. When no read was presented, `dec_valid`, `ce` and `ue` are low.
- R8: The correctable counter increments once for every correctable read, and the uncorrectable counter once for every uncorrectable read.
- R9: Each counter stops at all ones and holds there on further events.
- R10: `cnt_clr` zeroes both counters at the next clock edge. It wins over an error event in the same cycle, which is then not counted; the flag for that read is still raised.
- R11: After reset all registered outputs and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_data | input | 64 | Data word to be stored |
| wr_check | output | 8 | Check bits for `wr_data` (combinational) |
| rd_valid | input | 1 | A stored word is presented for decoding |
| rd_data | input | 64 | Stored data word |
| rd_check | input | 8 | Stored check bits |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| dec_valid | output | 1 | Decoded result valid |
| dec_data | output | 64 | Decoded (corrected) data |
| ce | output | 1 | Correctable error was repaired |
| ue | output | 1 | Uncorrectable error detected |
| ce_count | output | CNT_W | Saturating count of correctable errors |
| ue_count | output | CNT_W | Saturating count of uncorrectable errors |

## Verification
Two things can coincide in one cycle: a software clear of the counters and a read that carries an error. The bench provokes this by asserting `cnt_clr` together with `rd_valid` on a word with one injected flip, and again on a word with two.

It then expects the flag for that read to be raised while the matching counter reads zero afterwards. The next erroneous read must count from zero.

Saturation is reached with a narrow counter width, and repeated events must then leave the count at all ones.

// File: rtl/secded_pkg.sv
// Shared constants and constant functions for the SEC-DED codec.
// Assumes the check width can supply at least DATA_W distinct odd-weight
// columns of weight three or more.
package secded_pkg;
    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int CODE_W = DATA_W + CHK_W;

    // Population count of one check-width value.
    function automatic int weight_of(input logic [CHK_W-1:0] v);
        int n;
        n = 0;
        for (int b = 0; b < CHK_W; b++) n += int'(v[b]);
        return n;
    endfunction

    // Data columns: all weight-3 values in ascending order, then weight 5, ...
    function automatic logic [DATA_W*CHK_W-1:0] build_cols();
        logic [DATA_W*CHK_W-1:0] cols;
        int idx;
        cols = '0;
        idx  = 0;
        for (int w = 3; w <= CHK_W; w += 2) begin
            for (int v = 1; v < (1 << CHK_W); v++) begin
                if (idx < DATA_W && weight_of(CHK_W'(v)) == w) begin
                    cols[idx*CHK_W +: CHK_W] = CHK_W'(v);
                    idx++;
                end
            end
        end
        return cols;
    endfunction

    localparam logic [DATA_W*CHK_W-1:0] H_COLS = build_cols();

    // Mask of data bits that feed check bit j.
    function automatic logic [DATA_W-1:0] row_mask(input int j);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) m[i] = H_COLS[i*CHK_W + j];
        return m;
    endfunction
endpackage

// File: rtl/secded_enc.sv
// Check-bit generator: check bit j is the XOR of the data bits whose matrix
// column has a one in row j. Purely combinational; used on both paths.
module secded_enc
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  check
);
    // One XOR tree per check row.
    for (genvar j = 0; j < CHK_W; j++) begin : g_row
        localparam logic [DATA_W-1:0] MASK = row_mask(j);
        assign check[j] = ^(data & MASK);
    end

    // R2: each single-one data word must give odd-weight check bits
    always_comb begin
        if ($onehot(data)) begin
            p_odd_column_r2: assert (^check)
                else $error("even-weight column in matrix");
        end
    end
endmodule

// File: rtl/secded_dec.sv
// Syndrome decoder with one output register stage. Classifies the word as
// clean, single (correctable) or uncorrectable, repairs single data-bit flips,
// and exposes the unregistered event strobes for the counters.
// Assumes recomputed check bits of rd_data arrive on calc_check.
module secded_dec
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_check,
    input  logic [CHK_W-1:0]  calc_check,
    output logic              ce_evt,
    output logic              ue_evt,
    output logic              dec_valid,
    output logic [DATA_W-1:0] dec_data,
    output logic              ce,
    output logic              ue
);
    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] flip;
    logic              odd_w, nonzero, chk_hit, any_hit, ce_c, ue_c;

    assign syn = calc_check ^ rd_check;

    // Match the syndrome against every data column.
    for (genvar i = 0; i < DATA_W; i++) begin : g_match
        assign flip[i] = (syn == H_COLS[i*CHK_W +: CHK_W]);
    end

    // Classify the syndrome: odd weight with a column match is correctable.
    always_comb begin
        odd_w   = ^syn;
        nonzero = |syn;
        chk_hit = $onehot(syn);
        any_hit = (|flip) | chk_hit;
        ce_c    = odd_w & any_hit;
        ue_c    = nonzero & ~ce_c;
    end

    assign ce_evt = rd_valid & ce_c;
    assign ue_evt = rd_valid & ue_c;

    // Output register: result and flags one cycle after rd_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_data  <= '0;
            ce        <= 1'b0;
            ue        <= 1'b0;
        end else begin
            dec_valid <= rd_valid;
            ce        <= ce_evt;
            ue        <= ue_evt;
            if (rd_valid) dec_data <= ce_c ? (rd_data ^ flip) : rd_data;
        end
    end

    // R5: never both flags
    p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ce, ue}));
    // R7: result follows a read by one cycle
    p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> dec_valid);
    // R7: no flags without a read
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> (!ce && !ue && !dec_valid));
    // R3: agreeing check bits pass data through unchanged
    p_clean_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_check == calc_check) |=>
        (dec_data == $past(rd_data) && !ce && !ue));
endmodule

// File: rtl/secded_cnt.sv
// Saturating event counter with synchronous clear. Clear wins over an event
// in the same cycle. Assumes inc is a single-cycle strobe per event.
module secded_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count events, hold at all ones, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (clr)                   cnt <= '0;
        else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // R10: clear takes effect next edge
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    // R9: saturated count holds
    p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));
    // R8: one step per event below saturation
    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));
    // R8: no event, no change
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt));
endmodule

// File: rtl/secded_codec.sv
// Top of the SEC-DED codec: write-side check-bit generator, read-side
// syndrome decoder with one register stage, and two saturating counters
// for correctable and uncorrectable events.
module secded_codec
    import secded_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CHK_W-1:0]  wr_check,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_check,
    input  logic              cnt_clr,
    output logic              dec_valid,
    output logic [DATA_W-1:0] dec_data,
    output logic              ce,
    output logic              ue,
    output logic [CNT_W-1:0]  ce_count,
    output logic [CNT_W-1:0]  ue_count
);
    logic [CHK_W-1:0] rd_calc;
    logic             ce_evt, ue_evt;

    secded_enc u_enc_wr (.data(wr_data), .check(wr_check));
    secded_enc u_enc_rd (.data(rd_data), .check(rd_calc));

    secded_dec u_dec (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_check(rd_check), .calc_check(rd_calc), .ce_evt(ce_evt),
        .ue_evt(ue_evt), .dec_valid(dec_valid), .dec_data(dec_data),
        .ce(ce), .ue(ue)
    );

    secded_cnt #(.CNT_W(CNT_W)) u_cnt_ce (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(ce_evt), .cnt(ce_count));
    secded_cnt #(.CNT_W(CNT_W)) u_cnt_ue (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(ue_evt), .cnt(ue_count));

    // R8: a raised ce flag came with a counter change or a clear or saturation
    p_ce_logged_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ce_evt |=> (ce && (ce_count != $past(ce_count) || $past(cnt_clr)
                    || ce_count == {CNT_W{1'b1}})));
endmodule

// File: tb/secded_codec_bench.sv
module secded_codec_bench;
    localparam int CW = 4;
    localparam logic [CW-1:0] MAXC = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   wr_data = '0;
    logic [7:0]    wr_check;
    logic          rd_valid = 1'b0;
    logic [63:0]   rd_data = '0;
    logic [7:0]    rd_check = '0;
    logic          cnt_clr = 1'b0;
    logic          dec_valid, ce, ue;
    logic [63:0]   dec_data;
    logic [CW-1:0] ce_count, ue_count;

    int checks = 0, fails = 0;
    logic [CW-1:0] m_ce = '0, m_ue = '0;
    bit done = 0;

    always #4 clk = ~clk;

    secded_codec #(.CNT_W(CW)) u_secded_codec (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_check(wr_check),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_check(rd_check),
        .cnt_clr(cnt_clr), .dec_valid(dec_valid), .dec_data(dec_data),
        .ce(ce), .ue(ue), .ce_count(ce_count), .ue_count(ue_count));

    function automatic int pop8(input logic [7:0] v);
        int n = 0;
        for (int b = 0; b < 8; b++) n += int'(v[b]);
        return n;
    endfunction

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
        return (v == MAXC) ? v : v + 1'b1;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic encode(input logic [63:0] d, output logic [7:0] c);
        wr_data = d;
        #1;
        c = wr_check;
    endtask

    // mode: 0 clean, 1 single, 2 double, 3 weight-7 syndrome
    task automatic do_read(input logic [63:0] d, input int mode, input bit clr, input string req);
        logic [7:0]  c;
        logic [71:0] word, fm;
        int p1, p2;
        logic e_ce, e_ue;
        logic [63:0] e_data;
        @(negedge clk);
        encode(d, c);
        fm = '0;
        if (mode == 1) begin
            p1 = $urandom_range(71);
            fm[p1] = 1'b1;
        end else if (mode == 2) begin
            p1 = $urandom_range(71);
            p2 = (p1 + 1 + $urandom_range(70)) % 72;
            fm[p1] = 1'b1;
            fm[p2] = 1'b1;
        end else if (mode == 3) begin
            fm[71:64] = 8'h7F;
        end
        word = {c, d} ^ fm;
        rd_data  = word[63:0];
        rd_check = word[71:64];
        rd_valid = 1'b1;
        cnt_clr  = clr;
        e_ce   = (mode == 1);
        e_ue   = (mode >= 2);
        e_data = (mode >= 2) ? word[63:0] : d;
        if (clr) begin
            m_ce = '0;
            m_ue = '0;
        end else begin
            if (e_ce) m_ce = sat_inc(m_ce);
            if (e_ue) m_ue = sat_inc(m_ue);
        end
        @(negedge clk);
        rd_valid = 1'b0;
        cnt_clr  = 1'b0;
        chk({req, " R7 dec_valid"}, 64'(dec_valid), 64'd1);
        chk({req, " data"}, dec_data, e_data);
        chk({req, " ce"}, 64'(ce), 64'(e_ce));
        chk({req, " ue"}, 64'(ue), 64'(e_ue));
        chk({req, " R8 ce_count"}, 64'(ce_count), 64'(m_ce));
        chk({req, " R8 ue_count"}, 64'(ue_count), 64'(m_ue));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] c1, c2, c3;
        logic [63:0] a, b;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 dec_valid", 64'(dec_valid), 0);
        chk("R11 ce", 64'(ce), 0);
        chk("R11 ue", 64'(ue), 0);
        chk("R11 dec_data", dec_data, 0);
        chk("R11 ce_count", 64'(ce_count), 0);
        chk("R11 ue_count", 64'(ue_count), 0);

        // R1: linearity
        encode('0, c1);
        chk("R1 zero data", 64'(c1), 0);
        for (int k = 0; k < 20; k++) begin
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            encode(a, c1);
            encode(b, c2);
            encode(a ^ b, c3);
            chk("R1 linear", 64'(c3), 64'(c1 ^ c2));
        end
        // R2: column weights
        for (int i = 0; i < 64; i++) begin
            encode(64'd1 << i, c1);
            chk("R2 column weight", 64'(pop8(c1)), (i < 56) ? 64'd3 : 64'd5);
        end

        // Directed corners
        do_read(64'h0, 0, 0, "R3 clean zero");
        do_read('1, 0, 0, "R3 clean ones");
        do_read(64'h0123_4567_89AB_CDEF, 1, 0, "R4 single");
        do_read(64'hFFFF_0000_FFFF_0000, 2, 0, "R5 double");
        do_read(64'h3938_3736_3534_3332, 3, 0, "R6 unmatched odd");
        // R7: no read, no flags
        @(negedge clk);
        chk("R7 idle dec_valid", 64'(dec_valid), 0);
        chk("R7 idle ce", 64'(ce), 0);
        chk("R7 idle ue", 64'(ue), 0);
        // R10: clear colliding with an error event
        do_read({$urandom, $urandom}, 1, 1, "R10 clear+single");
        do_read({$urandom, $urandom}, 2, 1, "R10 clear+double");
        do_read({$urandom, $urandom}, 1, 0, "R10 count after clear");

        // Constrained random mix
        for (int k = 0; k < 400; k++) begin
            automatic int mode = $urandom_range(3);
            do_read({$urandom, $urandom}, mode, ($urandom_range(39) == 0), "R4/R5 random");
        end

        // R9: saturation
        do_read('0, 0, 1, "R9 clear");
        for (int k = 0; k < 20; k++) do_read({$urandom, $urandom}, 1, 0, "R9 ce sat");
        for (int k = 0; k < 20; k++) do_read({$urandom, $urandom}, 2, 0, "R9 ue sat");
        chk("R9 ce held", 64'(ce_count), 64'(MAXC));
        chk("R9 ue held", 64'(ue_count), 64'(MAXC));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule